// File: doc/BRIEF.md
# Bridge Address-Window Forwarding Decoder

This block sits on the upstream (primary) side of a switch port or root port. It decides, for each request it sees, whether the address lies in the space that belongs below the port. If it does, the request is forwarded to the downstream (secondary) side. Three windows describe that space, and each is programmed with a base and a limit. The first covers prefetchable memory and takes a full 64-bit range with 1 MB granularity. The second covers non-prefetchable memory, reaches only the low 4 GB, and also has 1 MB granularity. The third covers I/O space, holds 16-bit values and has 4 KB granularity.

Software programs the windows through a single-cycle write port: an enable, a register select and a data word. Each request enters with a valid bit, a type and an address. One clock later the block returns a forward flag and a code for the window that claimed the request. A window whose base is above its limit is switched off. Every window starts in that state after reset, so nothing is forwarded until software programs a window.

Top module: `bridge_window_decoder`

## Requirements
- R1: After reset all three windows are disabled, and no request of any type or address is forwarded until a window is programmed. fwdValid, fwdHit and fwdWindow are all 0 during reset.
- R2: fwdValid equals the reqValid of the previous cycle. fwdHit is 1 only when fwdValid is 1, and it is 0 for any cycle whose request had reqValid low.
- R3: A prefetchable request (reqType 1) hits the prefetchable window (fwdWindow 1) when base <= address <= limit, using all 64 address bits. The low 20 bits of the base are taken as zero, and the low 20 bits of the limit are taken as ones.
- R4: A non-prefetchable request (reqType 0) hits the non-prefetchable window (fwdWindow 2) only when address bits 63:32 are zero and the low 32 bits lie in the window. The base is aligned down to 1 MB, and the limit is filled up to the end of its 1 MB block.
- R5: An I/O request (reqType 2) hits the I/O window (fwdWindow 3) only when address bits 63:16 are zero and bits 15:0 lie in the window. The base is aligned down to 4 KB, and the limit is filled up to the end of its 4 KB block.
- R6: A prefetchable request that misses the prefetchable window is still forwarded, with fwdWindow 2, if it satisfies the R4 condition for the non-prefetchable window. When both windows match, the prefetchable window wins.
- R7: A non-prefetchable request never matches the prefetchable or I/O window, and an I/O request never matches either memory window.
- R8: Any window whose aligned base is greater than its filled limit is disabled and matches no address.
- R9: Register select encoding on cfgWrSel: 0 = prefetchable base bits 31:0, 1 = prefetchable base bits 63:32, 2 = prefetchable limit bits 31:0, 3 = prefetchable limit bits 63:32, 4 = non-prefetchable base, 5 = non-prefetchable limit, 6 = I/O base (data bits 15:0), 7 = I/O limit (data bits 15:0). A write is applied at the clock edge, so a request presented in the same cycle still sees the old value.
- R10: reqType 3 is reserved and never forwarded. fwdWindow is 0 whenever fwdHit is 0.
- R11: The window edges are inclusive: an address equal to the aligned base or to the filled limit hits, and the address one past either edge misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Register write strobe |
| cfgWrSel | input | 3 | Register select (encoding in R9) |
| cfgWrData | input | 32 | Register write data |
| reqValid | input | 1 | A request is present |
| reqType | input | 2 | 0 non-prefetchable memory, 1 prefetchable memory, 2 I/O, 3 reserved |
| reqAddr | input | 64 | Request address |
| fwdValid | output | 1 | Decision valid, one cycle after reqValid |
| fwdHit | output | 1 | Forward the request downstream |
| fwdWindow | output | 2 | Window that matched: 0 none, 1 prefetchable, 2 non-prefetchable, 3 I/O |

## Verification
The bench builds the block with its default parameters: a 32-bit write word (so 64-bit addresses), 1 MB granularity on both memory windows, and a 16-bit I/O window with 4 KB granularity. Because of these values, addresses at and just beyond every aligned edge can be written out directly. The same values let the bench choose addresses whose upper bits are set to exercise the 4 GB and 64 KB ceilings. They also let it place the prefetchable window over the non-prefetchable one so that the priority between them becomes visible.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

  typedef enum logic [1:0] {
    REQ_MEM_NP = 2'd0,
    REQ_MEM_PF = 2'd1,
    REQ_IO     = 2'd2,
    REQ_RSVD   = 2'd3
  } reqKind_t;

  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_PREF  = 2'd1,
    WIN_NPMEM = 2'd2,
    WIN_IO    = 2'd3
  } winId_t;

  // one strobe per programmable register half
  typedef struct packed {
    logic prefBaseLo;
    logic prefBaseHi;
    logic prefLimLo;
    logic prefLimHi;
    logic npBase;
    logic npLim;
    logic ioBase;
    logic ioLim;
  } wrStrobe_t;

endpackage

// File: rtl/bwd_window_cmp.sv
// Inclusive range compare for one window with granularity alignment.
module bwd_window_cmp #(
  parameter int W     = 32,
  parameter int ALIGN = 20
) (
  input  logic [W-1:0] baseRaw,
  input  logic [W-1:0] limRaw,
  input  logic [W-1:0] addr,
  output logic         inWin
);
  localparam logic [W-1:0] LOW_MASK = {{(W-ALIGN){1'b0}}, {ALIGN{1'b1}}};

  logic [W-1:0] effBase;
  logic [W-1:0] effLim;
  logic         enabled;

  always_comb begin
    effBase = baseRaw & ~LOW_MASK;
    effLim  = limRaw | LOW_MASK;
    enabled = (effBase <= effLim);
    inWin   = enabled && (addr >= effBase) && (addr <= effLim);
  end
endmodule

// File: rtl/bwd_datapath.sv
// Window registers and the three range comparators.
module bwd_datapath
  import bwd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IO_W       = 16,
  parameter int PREF_ALIGN = 20,
  parameter int NP_ALIGN   = 20,
  parameter int IO_ALIGN   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  wrStrobe_t           strobe,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [2*DATA_W-1:0] addr,
  output logic                inPref,
  output logic                inNp,
  output logic                inIo
);
  localparam int ADDR_W = 2 * DATA_W;

  logic [ADDR_W-1:0] prefBase, prefLim;
  logic [DATA_W-1:0] npBase, npLim;
  logic [IO_W-1:0]   ioBase, ioLim;

  // reset leaves every base above its limit: all windows off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prefBase <= '1;
      prefLim  <= '0;
      npBase   <= '1;
      npLim    <= '0;
      ioBase   <= '1;
      ioLim    <= '0;
    end else begin
      if (strobe.prefBaseLo) prefBase[DATA_W-1:0]      <= wrData;
      if (strobe.prefBaseHi) prefBase[ADDR_W-1:DATA_W] <= wrData;
      if (strobe.prefLimLo)  prefLim[DATA_W-1:0]       <= wrData;
      if (strobe.prefLimHi)  prefLim[ADDR_W-1:DATA_W]  <= wrData;
      if (strobe.npBase)     npBase <= wrData;
      if (strobe.npLim)      npLim  <= wrData;
      if (strobe.ioBase)     ioBase <= wrData[IO_W-1:0];
      if (strobe.ioLim)      ioLim  <= wrData[IO_W-1:0];
    end
  end

  logic prefCmp, npCmp, ioCmp;
  logic npReach, ioReach;

  bwd_window_cmp #(.W(ADDR_W), .ALIGN(PREF_ALIGN)) uPrefCmp (
    .baseRaw(prefBase), .limRaw(prefLim), .addr(addr), .inWin(prefCmp));

  bwd_window_cmp #(.W(DATA_W), .ALIGN(NP_ALIGN)) uNpCmp (
    .baseRaw(npBase), .limRaw(npLim), .addr(addr[DATA_W-1:0]), .inWin(npCmp));

  bwd_window_cmp #(.W(IO_W), .ALIGN(IO_ALIGN)) uIoCmp (
    .baseRaw(ioBase), .limRaw(ioLim), .addr(addr[IO_W-1:0]), .inWin(ioCmp));

  always_comb begin
    npReach = (addr[ADDR_W-1:DATA_W] == '0);
    ioReach = (addr[ADDR_W-1:IO_W] == '0);
    inPref  = prefCmp;
    inNp    = npCmp && npReach;
    inIo    = ioCmp && ioReach;
  end
endmodule

// File: rtl/bwd_ctrl.sv
// Write-select decode and per-type window selection with the output stage.
module bwd_ctrl
  import bwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgWrEn,
  input  logic [2:0] cfgWrSel,
  input  logic       reqValid,
  input  logic [1:0] reqType,
  input  logic       inPref,
  input  logic       inNp,
  input  logic       inIo,
  output wrStrobe_t  strobe,
  output logic       fwdValid,
  output logic       fwdHit,
  output logic [1:0] fwdWindow
);
  logic [7:0] selHot;

  for (genvar i = 0; i < 8; i++) begin : gSel
    assign selHot[i] = cfgWrEn && (cfgWrSel == 3'(i));
  end

  always_comb begin
    strobe.prefBaseLo = selHot[0];
    strobe.prefBaseHi = selHot[1];
    strobe.prefLimLo  = selHot[2];
    strobe.prefLimHi  = selHot[3];
    strobe.npBase     = selHot[4];
    strobe.npLim      = selHot[5];
    strobe.ioBase     = selHot[6];
    strobe.ioLim      = selHot[7];
  end

  winId_t winNxt;
  logic   hitNxt;

  always_comb begin
    winNxt = WIN_NONE;
    unique case (reqKind_t'(reqType))
      REQ_MEM_PF: begin
        if (inPref)    winNxt = WIN_PREF;
        else if (inNp) winNxt = WIN_NPMEM;
      end
      REQ_MEM_NP: if (inNp) winNxt = WIN_NPMEM;
      REQ_IO:     if (inIo) winNxt = WIN_IO;
      default:    winNxt = WIN_NONE;
    endcase
    hitNxt = reqValid && (winNxt != WIN_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwdValid  <= 1'b0;
      fwdHit    <= 1'b0;
      fwdWindow <= WIN_NONE;
    end else begin
      fwdValid  <= reqValid;
      fwdHit    <= hitNxt;
      fwdWindow <= hitNxt ? winNxt : WIN_NONE;
    end
  end
endmodule

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder
  import bwd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IO_W       = 16,
  parameter int PREF_ALIGN = 20,
  parameter int NP_ALIGN   = 20,
  parameter int IO_ALIGN   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfgWrEn,
  input  logic [2:0]          cfgWrSel,
  input  logic [DATA_W-1:0]   cfgWrData,
  input  logic                reqValid,
  input  logic [1:0]          reqType,
  input  logic [2*DATA_W-1:0] reqAddr,
  output logic                fwdValid,
  output logic                fwdHit,
  output logic [1:0]          fwdWindow
);
  wrStrobe_t strobe;
  logic      inPref, inNp, inIo;

  bwd_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .reqValid(reqValid), .reqType(reqType),
    .inPref(inPref), .inNp(inNp), .inIo(inIo), .strobe(strobe),
    .fwdValid(fwdValid), .fwdHit(fwdHit), .fwdWindow(fwdWindow));

  bwd_datapath #(
    .DATA_W(DATA_W), .IO_W(IO_W), .PREF_ALIGN(PREF_ALIGN),
    .NP_ALIGN(NP_ALIGN), .IO_ALIGN(IO_ALIGN)
  ) uData (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(cfgWrData),
    .addr(reqAddr), .inPref(inPref), .inNp(inNp), .inIo(inIo));
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
  parameter int DATA_W = 32,
  parameter int IO_W   = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reqValid,
  input logic [1:0]          reqType,
  input logic [2*DATA_W-1:0] reqAddr,
  input logic                fwdValid,
  input logic                fwdHit,
  input logic [1:0]          fwdWindow
);
  logic pastOk;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pastOk <= 1'b0;
    else        pastOk <= 1'b1;
  end

  a_r2_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fwdHit |-> fwdValid);

  a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n || !pastOk)
    fwdValid == $past(reqValid));

  a_r10_window_matches_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fwdHit == (fwdWindow != 2'd0));

  a_r10_reserved_never: assert property (@(posedge clk) disable iff (!rst_n || !pastOk)
    ($past(reqType) == 2'd3) |-> !fwdHit);

  a_r5_io_below_ceiling: assert property (@(posedge clk) disable iff (!rst_n || !pastOk)
    (fwdWindow == 2'd3) |-> ($past(reqType) == 2'd2 && $past(reqAddr[2*DATA_W-1:IO_W]) == '0));

  a_r4_np_below_ceiling: assert property (@(posedge clk) disable iff (!rst_n || !pastOk)
    (fwdWindow == 2'd2) |-> ($past(reqType) != 2'd2 && $past(reqAddr[2*DATA_W-1:DATA_W]) == '0));

  a_r7_pref_only_pf: assert property (@(posedge clk) disable iff (!rst_n || !pastOk)
    (fwdWindow == 2'd1) |-> ($past(reqType) == 2'd1));
endmodule

bind bridge_window_decoder bwd_checker #(.DATA_W(DATA_W), .IO_W(IO_W)) uChk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqType(reqType),
  .reqAddr(reqAddr), .fwdValid(fwdValid), .fwdHit(fwdHit), .fwdWindow(fwdWindow));

// File: tb/sim_bridge_window_decoder.sv
`timescale 1ns/1ps
module sim_bridge_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgWrSel = '0;
  logic [31:0] cfgWrData = '0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqType = '0;
  logic [63:0] reqAddr = '0;
  logic        fwdValid, fwdHit;
  logic [1:0]  fwdWindow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bridge_window_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrData(cfgWrData), .reqValid(reqValid), .reqType(reqType),
    .reqAddr(reqAddr), .fwdValid(fwdValid), .fwdHit(fwdHit), .fwdWindow(fwdWindow));

  // reference state: raw register images
  logic [63:0] mPB = '1, mPL = '0;
  logic [31:0] mNB = '1, mNL = '0;
  logic [15:0] mIB = '1, mIL = '0;

  localparam logic [63:0] PF_LOW = 64'h0000_0000_000F_FFFF;
  localparam logic [31:0] NP_LOW = 32'h000F_FFFF;
  localparam logic [15:0] IO_LOW = 16'h0FFF;

  function automatic bit inRange(input logic [63:0] a, lo, hi);
    return (lo <= hi) && (a >= lo) && (a <= hi);
  endfunction

  function automatic logic [1:0] refWin(input logic [1:0] t, input logic [63:0] a);
    bit pf, np, io;
    pf = inRange(a, mPB & ~PF_LOW, mPL | PF_LOW);
    np = (a < 64'h1_0000_0000) &&
         inRange(a, {32'd0, mNB & ~NP_LOW}, {32'd0, mNL | NP_LOW});
    io = (a < 64'h1_0000) &&
         inRange(a, {48'd0, mIB & ~IO_LOW}, {48'd0, mIL | IO_LOW});
    case (t)
      2'd1:    return pf ? 2'd1 : (np ? 2'd2 : 2'd0);
      2'd0:    return np ? 2'd2 : 2'd0;
      2'd2:    return io ? 2'd3 : 2'd0;
      default: return 2'd0;
    endcase
  endfunction

  function automatic void refWrite(input logic [2:0] s, input logic [31:0] d);
    case (s)
      3'd0: mPB[31:0]  = d;
      3'd1: mPB[63:32] = d;
      3'd2: mPL[31:0]  = d;
      3'd3: mPL[63:32] = d;
      3'd4: mNB = d;
      3'd5: mNL = d;
      3'd6: mIB = d[15:0];
      default: mIL = d[15:0];
    endcase
  endfunction

  // one clock: drive at negedge, predict, compare at the following negedge
  task automatic step(input bit we, input logic [2:0] sel, input logic [31:0] d,
                      input bit rv, input logic [1:0] t, input logic [63:0] a,
                      input string tag);
    logic [1:0] eW;
    bit eV, eH;
    cfgWrEn = we; cfgWrSel = sel; cfgWrData = d;
    reqValid = rv; reqType = t; reqAddr = a;
    eV = rv;
    eW = rv ? refWin(t, a) : 2'd0;
    eH = (eW != 2'd0);
    @(posedge clk);
    if (we) refWrite(sel, d);
    @(negedge clk);
    checks++;
    if (fwdValid !== eV || fwdHit !== eH || fwdWindow !== eW) begin
      fails++;
      $display("FAIL %s: type %0d addr %h got v/h/w %0b/%0b/%0d expected %0b/%0b/%0d",
               tag, t, a, fwdValid, fwdHit, fwdWindow, eV, eH, eW);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    step(1'b1, sel, d, 1'b0, 2'd0, 64'd0, "R9_write");
  endtask

  task automatic rq(input logic [1:0] t, input logic [63:0] a, input string tag);
    step(1'b0, 3'd0, 32'd0, 1'b1, t, a, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (fwdValid !== 1'b0 || fwdHit !== 1'b0 || fwdWindow !== 2'd0) begin
      fails++;
      $display("FAIL R1 reset outputs: got %0b/%0b/%0d expected 0/0/0", fwdValid, fwdHit, fwdWindow);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1: nothing forwarded before programming
    rq(2'd0, 64'h0, "R1_np");
    rq(2'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R1_pf");
    rq(2'd1, 64'h0, "R1_pf0");
    rq(2'd2, 64'h0, "R1_io");

    // prefetchable window 0x1_2340_0000 .. 0x1_236F_FFFF
    wr(3'd0, 32'h2345_6789); wr(3'd1, 32'h1);
    wr(3'd2, 32'h2360_0000); wr(3'd3, 32'h1);
    rq(2'd1, 64'h1_2340_0000, "R11_pf_base");
    rq(2'd1, 64'h1_233F_FFFF, "R11_pf_below");
    rq(2'd1, 64'h1_236F_FFFF, "R11_pf_limit");
    rq(2'd1, 64'h1_2370_0000, "R11_pf_above");
    rq(2'd1, 64'h1_2355_5555, "R3_pf_mid");
    rq(2'd1, 64'h0_2355_5555, "R3_pf_upper_bits");
    rq(2'd0, 64'h1_2355_5555, "R7_np_in_pref");

    // R9: write and request in the same cycle see the old value
    step(1'b1, 3'd4, 32'h8000_0000, 1'b1, 2'd0, 64'h8000_0000, "R9_same_cycle_base");
    step(1'b1, 3'd5, 32'h80F0_0000, 1'b1, 2'd0, 64'h8000_0000, "R9_same_cycle_limit");
    rq(2'd0, 64'h8000_0000, "R9_after_write");
    rq(2'd0, 64'h80FF_FFFF, "R4_np_limit");
    rq(2'd0, 64'h8100_0000, "R4_np_above");
    rq(2'd0, 64'h7FFF_FFFF, "R4_np_below");
    rq(2'd0, 64'h1_8000_0000, "R4_np_upper_bits");

    // R6: prefetchable request falls back to the non-prefetchable window
    rq(2'd1, 64'h8000_1000, "R6_pf_fallback");
    rq(2'd1, 64'h1_8000_1000, "R6_pf_fallback_high");

    // overlap: prefetchable 0x8000_0000..0x800F_FFFF wins for PF
    wr(3'd0, 32'h8000_0000); wr(3'd1, 32'h0);
    wr(3'd3, 32'h0); wr(3'd2, 32'h8000_0000);
    rq(2'd1, 64'h8000_0000, "R6_priority");
    rq(2'd1, 64'h8010_0000, "R6_outside_pref");
    rq(2'd0, 64'h8000_0000, "R7_np_ignores_pref");

    // I/O window 0x2000 .. 0x3FFF
    wr(3'd6, 32'hABCD_2345); wr(3'd7, 32'h0000_3000);
    rq(2'd2, 64'h2000, "R11_io_base");
    rq(2'd2, 64'h3FFF, "R11_io_limit");
    rq(2'd2, 64'h4000, "R5_io_above");
    rq(2'd2, 64'h1FFF, "R5_io_below");
    rq(2'd2, 64'h1_2000, "R5_io_upper_bits");
    rq(2'd0, 64'h2000, "R7_np_at_io");
    rq(2'd2, 64'h8000_0000, "R7_io_at_mem");

    // R8: base above limit disables; single granule works
    wr(3'd7, 32'h1000);
    rq(2'd2, 64'h2000, "R8_io_disabled");
    rq(2'd2, 64'h1800, "R8_io_disabled_low");
    wr(3'd7, 32'h2000);
    rq(2'd2, 64'h2FFF, "R8_io_one_granule");
    wr(3'd5, 32'h7000_0000);
    rq(2'd0, 64'h8000_0000, "R8_np_disabled");
    rq(2'd1, 64'h8010_0000, "R8_pf_no_fallback");

    // R10 reserved type; R2 no valid
    rq(2'd3, 64'h8000_0000, "R10_reserved");
    step(1'b0, 3'd0, 32'd0, 1'b0, 2'd1, 64'h8000_0000, "R2_no_valid");
    rq(2'd1, 64'h8000_0000, "R2_valid_again");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule